// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time as four BCD bytes: tenths of a second, seconds, minutes, and a 12-hour hours byte whose bit 7 is the PM flag. It holds a second set of four bytes for an alarm time. An external one-cycle `tick` strobe arrives every tenth of a second, and each strobe moves the running clock forward by one tenth, with BCD carries into the higher bytes. Software reaches both register sets through a small port. `addr` selects the byte: 0 is tenths, 1 is seconds, 2 is minutes and 3 is hours. The `alarm_sel` input decides whether a write goes to the clock or to the alarm. Reads always return clock bytes.

Setting the time is a sequence. A clock write to the hours byte halts counting, and a clock write to the tenths byte resumes it, so software writes hours first and tenths last. Reading works the same way. Reads go through a snapshot latch: a read of hours freezes the snapshot and a read of tenths releases it, so a read sequence from hours down to tenths sees one consistent time while the clock keeps counting. When the running clock comes to equal the alarm, after a write or after a tick, the block raises a one-cycle `alarm_hit` pulse. A neighbouring interrupt register holds that pulse as its flag bit 2.

Top module: `tod_clock_alarm`

## Requirements
- R1: After reset the clock is stopped and reads return tenths 0x00, seconds 0x00, minutes 0x00 and hours 0x01 (1 AM). `alarm_hit` is 0 and the read snapshot is released.
- R2: A write (`wr_en`=1) with `alarm_sel`=1 stores into the alarm byte selected by `addr` and leaves every clock byte unchanged. A write with `alarm_sel`=0 stores into the clock byte.
- R3: Every hours write is ANDed with 0x9F before it is stored. For a clock write only, if bits 4:0 of the masked value equal 0x12, bit 7 is inverted. An alarm hours write of 0x12 is stored as 0x12.
- R4: A clock write to hours (`addr`=3) stops the clock, and a clock write to tenths (`addr`=0) starts it. While the clock is stopped, `tick` has no effect.
- R5: Each `tick` while the clock is running advances tenths 0 to 9. On wrap, the carry moves seconds 00 to 59, then minutes 00 to 59, then the hours byte.
- R6: The hours byte counts 1 to 12. Going from 11 to 12 inverts bit 7 (AM/PM). Going from 12 to 01 keeps bit 7.
- R7: A read with the snapshot released first copies all four clock bytes into the snapshot. A read of hours freezes the snapshot and a read of tenths releases it. While frozen, reads return the snapshot and the clock keeps counting.
- R8: After a write to either register set, `alarm_hit` pulses if the clock is running and all four clock bytes equal the alarm bytes.
- R9: After a tick-driven advance, `alarm_hit` pulses if the new time equals the alarm.
- R10: A `tick` that arrives in the same cycle as a clock write is dropped. Only the write takes effect.
- R11: `rdata` is registered and holds the addressed byte in the cycle after `rd_en`. A read in the same cycle as a tick returns the value from before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle tenth-of-second strobe |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| alarm_sel | input | 1 | 1: writes go to the alarm set, 0: to the clock |
| addr | input | 2 | Byte select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| alarm_hit | output | 1 | One-cycle pulse when the running clock equals the alarm |

## Verification
Two pairs of events can fall in the same cycle: a tick with a clock write, and a tick with a read. The bench drives `tick` and `wr_en` together, then reads all four bytes back to confirm that only the written byte changed and that tenths did not advance. It also raises `tick` together with an hours read and checks two things: the frozen snapshot holds the tenths value from before the tick, and a second tenths read shows the live clock has moved on. Alarm matches are provoked both by completing a write sequence and by ticking into the alarm time.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int HR_MASK = 8'h9F;

    localparam logic [ADDR_W-1:0] A_TEN = 2'd0;
    localparam logic [ADDR_W-1:0] A_SEC = 2'd1;
    localparam logic [ADDR_W-1:0] A_MIN = 2'd2;
    localparam logic [ADDR_W-1:0] A_HR  = 2'd3;

    typedef struct packed {
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] ten;
    } tod_t;

    localparam tod_t TOD_RESET = '{hr: 8'h01, min: 8'h00, sec: 8'h00, ten: 8'h00};

    // BCD step with wrap at lim; bit 8 is the carry out
    function automatic logic [BYTE_W:0] bcd_step(input logic [BYTE_W-1:0] v,
                                                 input logic [BYTE_W-1:0] lim);
        logic [BYTE_W:0] r;
        if (v == lim)
            r = '0;
        else if (v[3:0] == 4'h9)
            r = {1'b0, v[7:4] + 4'h1, 4'h0};
        else
            r = {1'b0, v + 8'h01};
        if (v == lim)
            r[BYTE_W] = 1'b1;
        return r;
    endfunction

    // 12-hour advance with PM flag in bit 7
    function automatic logic [BYTE_W-1:0] hour_step(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        logic [4:0] h;
        h = v[4:0];
        r = v;
        if (h == 5'h12)
            r[4:0] = 5'h01;
        else if (h == 5'h11) begin
            r[4:0] = 5'h12;
            r[7]   = ~v[7];
        end else if (h[3:0] == 4'h9)
            r[4:0] = 5'h10;
        else
            r[4:0] = h + 5'h01;
        return r;
    endfunction

    // Hours write conversion
    function automatic logic [BYTE_W-1:0] hour_fix(input logic [BYTE_W-1:0] d,
                                                   input logic to_clock);
        logic [BYTE_W-1:0] r;
        r = d & HR_MASK[BYTE_W-1:0];
        if (to_clock && (r[4:0] == 5'h12))
            r[7] = ~r[7];
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] pick(input tod_t t, input logic [ADDR_W-1:0] a);
        logic [BYTE_W-1:0] r;
        case (a)
            A_TEN:   r = t.ten;
            A_SEC:   r = t.sec;
            A_MIN:   r = t.min;
            default: r = t.hr;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output tod_t              now,
    output logic              running,
    output tod_t              now_nxt,
    output logic              run_nxt,
    output logic              advanced
);
    logic [BYTE_W:0] ten_s, sec_s, min_s;

    always_comb begin
        now_nxt  = now;
        run_nxt  = running;
        advanced = 1'b0;
        ten_s    = bcd_step(now.ten, 8'h09);
        sec_s    = bcd_step(now.sec, 8'h59);
        min_s    = bcd_step(now.min, 8'h59);
        if (wr) begin
            case (addr)
                A_TEN: begin
                    now_nxt.ten = wdata;
                    run_nxt     = 1'b1;
                end
                A_SEC: now_nxt.sec = wdata;
                A_MIN: now_nxt.min = wdata;
                default: begin
                    now_nxt.hr = hour_fix(wdata, 1'b1);
                    run_nxt    = 1'b0;
                end
            endcase
        end else if (tick && running) begin
            advanced    = 1'b1;
            now_nxt.ten = ten_s[BYTE_W-1:0];
            if (ten_s[BYTE_W]) begin
                now_nxt.sec = sec_s[BYTE_W-1:0];
                if (sec_s[BYTE_W]) begin
                    now_nxt.min = min_s[BYTE_W-1:0];
                    if (min_s[BYTE_W])
                        now_nxt.hr = hour_step(now.hr);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now     <= TOD_RESET;
            running <= 1'b0;
        end else begin
            now     <= now_nxt;
            running <= run_nxt;
        end
    end

    a_r4_hr_write_stops: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_HR) |=> !running);
    a_r4_ten_write_starts: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_TEN) |=> running);
    a_r4_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr) |=> $stable(now));
    a_r10_tick_dropped: assert property (@(posedge clk) disable iff (rst)
        (tick && wr && addr != A_TEN) |=> $stable(now.ten));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  tod_t              clk_nxt,
    input  logic              run_nxt,
    output logic              hit
);
    tod_t alm, alm_nxt;

    always_comb begin
        alm_nxt = alm;
        if (wr) begin
            case (addr)
                A_TEN:   alm_nxt.ten = wdata;
                A_SEC:   alm_nxt.sec = wdata;
                A_MIN:   alm_nxt.min = wdata;
                default: alm_nxt.hr  = hour_fix(wdata, 1'b0);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alm <= '0;
            hit <= 1'b0;
        end else begin
            alm <= alm_nxt;
            hit <= evt && run_nxt && (clk_nxt == alm_nxt);
        end
    end

    a_r8_hit_needs_event: assert property (@(posedge clk) disable iff (rst)
        !evt |=> !hit);
endmodule

// File: rtl/tod_rdlatch.sv
module tod_rdlatch
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  tod_t              live,
    output logic [BYTE_W-1:0] rdata
);
    tod_t snap;
    logic frozen;
    tod_t src;

    always_comb src = frozen ? snap : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap   <= TOD_RESET;
            frozen <= 1'b0;
            rdata  <= '0;
        end else if (rd) begin
            rdata <= pick(src, addr);
            if (!frozen)
                snap <= live;
            if (addr == A_HR)
                frozen <= 1'b1;
            else if (addr == A_TEN)
                frozen <= 1'b0;
        end
    end

    a_r7_hr_read_freezes: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_HR) |=> frozen);
    a_r7_ten_read_releases: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_TEN) |=> !frozen);
    a_r7_frozen_snap_stable: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(snap));
endmodule

// File: rtl/tod_clock_alarm.sv
module tod_clock_alarm
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              alarm_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              alarm_hit
);
    tod_t now, now_nxt;
    logic running, run_nxt, advanced;
    logic wr_clk, wr_alm;

    assign wr_clk = wr_en && !alarm_sel;
    assign wr_alm = wr_en &&  alarm_sel;

    tod_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .wr(wr_clk), .addr(addr),
        .wdata(wdata), .now(now), .running(running), .now_nxt(now_nxt),
        .run_nxt(run_nxt), .advanced(advanced)
    );

    tod_alarm u_alm (
        .clk(clk), .rst(rst), .wr(wr_alm), .evt(wr_en || advanced),
        .addr(addr), .wdata(wdata), .clk_nxt(now_nxt), .run_nxt(run_nxt),
        .hit(alarm_hit)
    );

    tod_rdlatch u_lat (
        .clk(clk), .rst(rst), .rd(rd_en), .addr(addr), .live(now), .rdata(rdata)
    );

    a_r8_hit_only_running: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |-> running);
    a_r2_alarm_write_keeps_clock: assert property (@(posedge clk) disable iff (rst)
        (wr_alm && !(tick && running)) |=> $stable(now));
endmodule

// File: tb/tb_tod_clock_alarm.sv
module tb_tod_clock_alarm;
    logic clk = 1'b0;
    logic rst, tick, wr_en, rd_en, alarm_sel;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic alarm_hit;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tod_clock_alarm dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .alarm_sel(alarm_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .alarm_hit(alarm_hit)
    );

    // {op[2], sel, addr[2], data[8], exp[8]}  op: 0 write, 1 read+check, 2 tick
    localparam int NV = 42;
    localparam logic [20:0] VEC [NV] = '{
        {2'd1,1'b0,2'd3,8'h00,8'h01}, {2'd1,1'b0,2'd2,8'h00,8'h00},
        {2'd1,1'b0,2'd1,8'h00,8'h00}, {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd2,1'b0,2'd0,8'h00,8'h00}, {2'd1,1'b0,2'd3,8'h00,8'h01},
        {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd0,1'b0,2'd3,8'h11,8'h00}, {2'd0,1'b0,2'd2,8'h59,8'h00},
        {2'd0,1'b0,2'd1,8'h59,8'h00}, {2'd0,1'b0,2'd0,8'h09,8'h00},
        {2'd2,1'b0,2'd0,8'h00,8'h00},
        {2'd1,1'b0,2'd3,8'h00,8'h92}, {2'd1,1'b0,2'd2,8'h00,8'h00},
        {2'd1,1'b0,2'd1,8'h00,8'h00}, {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd0,1'b0,2'd3,8'h12,8'h00}, {2'd1,1'b0,2'd3,8'h00,8'h92},
        {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd2,1'b0,2'd0,8'h00,8'h00}, {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd0,1'b0,2'd3,8'h92,8'h00}, {2'd1,1'b0,2'd3,8'h00,8'h12},
        {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd0,1'b0,2'd3,8'hF3,8'h00}, {2'd1,1'b0,2'd3,8'h00,8'h93},
        {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd0,1'b1,2'd2,8'h44,8'h00}, {2'd1,1'b0,2'd2,8'h00,8'h00},
        {2'd0,1'b0,2'd3,8'h91,8'h00}, {2'd0,1'b0,2'd2,8'h59,8'h00},
        {2'd0,1'b0,2'd1,8'h59,8'h00}, {2'd0,1'b0,2'd0,8'h09,8'h00},
        {2'd2,1'b0,2'd0,8'h00,8'h00},
        {2'd1,1'b0,2'd3,8'h00,8'h12}, {2'd1,1'b0,2'd2,8'h00,8'h00},
        {2'd1,1'b0,2'd1,8'h00,8'h00}, {2'd1,1'b0,2'd0,8'h00,8'h00},
        {2'd0,1'b0,2'd1,8'h58,8'h00}, {2'd2,1'b0,2'd0,8'h00,8'h00},
        {2'd1,1'b0,2'd1,8'h00,8'h58}, {2'd1,1'b0,2'd0,8'h00,8'h01}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one bus cycle; outputs sampled just after the edge that registers it
    task automatic cyc(input logic w, input logic r, input logic t, input logic s,
                       input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; tick = t; alarm_sel = s; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; tick = 0; alarm_sel = 0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        cyc(0, 1, 0, 0, a, 8'h00);
        chk(req, rdata, exp);
    endtask

    initial begin
        rst = 1; tick = 0; wr_en = 0; rd_en = 0; alarm_sel = 0; addr = 0; wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R1 hit after reset", {7'd0, alarm_hit}, 8'h00);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            case (v[20:19])
                2'd0: cyc(1, 0, 0, v[18], v[17:16], v[15:8]);
                2'd1: begin
                    cyc(0, 1, 0, 0, v[17:16], 8'h00);
                    chk($sformatf("R1-7 vector %0d", i), rdata, v[7:0]);
                end
                default: cyc(0, 0, 1, 0, 2'd0, 8'h00);
            endcase
        end

        // R3 alarm hours no flip, R8 match after write sequence
        cyc(1, 0, 0, 1, 2'd3, 8'h12);
        cyc(1, 0, 0, 1, 2'd2, 8'h59);
        cyc(1, 0, 0, 1, 2'd1, 8'h59);
        cyc(1, 0, 0, 1, 2'd0, 8'h09);
        chk("R8 no hit on mismatch", {7'd0, alarm_hit}, 8'h00);
        cyc(1, 0, 0, 0, 2'd3, 8'h92);
        chk("R8 no hit while stopped", {7'd0, alarm_hit}, 8'h00);
        cyc(1, 0, 0, 0, 2'd2, 8'h59);
        cyc(1, 0, 0, 0, 2'd1, 8'h59);
        cyc(1, 0, 0, 0, 2'd0, 8'h09);
        chk("R8 R3 hit on start write", {7'd0, alarm_hit}, 8'h01);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        chk("R9 no hit after leaving alarm", {7'd0, alarm_hit}, 8'h00);
        rd_chk("R6 12 to 01 keeps AM", 2'd3, 8'h01);
        rd_chk("R5 tenths wrap", 2'd0, 8'h00);

        // R9 tick-driven match at 01:00:00.3
        cyc(1, 0, 0, 1, 2'd3, 8'h01);
        cyc(1, 0, 0, 1, 2'd2, 8'h00);
        cyc(1, 0, 0, 1, 2'd1, 8'h00);
        cyc(1, 0, 0, 1, 2'd0, 8'h03);
        chk("R9 no hit before", {7'd0, alarm_hit}, 8'h00);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        chk("R9 no hit at .2", {7'd0, alarm_hit}, 8'h00);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        chk("R9 hit at .3", {7'd0, alarm_hit}, 8'h01);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        chk("R9 pulse ends", {7'd0, alarm_hit}, 8'h00);

        // R10 tick with clock write: clock at 01:00:00.4
        cyc(1, 0, 1, 0, 2'd1, 8'h20);
        rd_chk("R10 hr", 2'd3, 8'h01);
        rd_chk("R10 min", 2'd2, 8'h00);
        rd_chk("R10 sec written", 2'd1, 8'h20);
        rd_chk("R10 tenths not advanced", 2'd0, 8'h04);

        // R11 read with tick, R7 frozen snapshot while counting
        cyc(0, 1, 1, 0, 2'd3, 8'h00);
        chk("R11 hr read with tick", rdata, 8'h01);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        rd_chk("R7 R11 frozen pre-tick tenths", 2'd0, 8'h04);
        rd_chk("R7 live after release", 2'd0, 8'h07);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule